// File: doc/BRIEF.md
# Control-Transfer History Recorder

The block keeps a short history of the control transfers a processor core takes. Each time the core reports a taken branch, an interrupt or an exception, the block stores the address the transfer left from and the address it landed on. The pairs go into an eight-slot ring, and a top-of-stack index always names the newest pair. A debugger reads the history through a small register port. Entry k of the port returns the pair k steps older than the newest, so software can walk backwards from the point where a fault appeared.

Recording is gated by one enable bit in a control register. Software sets and clears that bit. Hardware also clears it on its own when the core reports a debug exception, so the history stops at the moment the debugger takes over. Stopping the recording never erases what is already stored. The debug exception itself is never entered into the history.

A two-state machine holds the enable. In `ST_OFF` nothing is captured. In `ST_REC` every qualifying transfer is captured. It moves between them on three named transitions:

- `T_ARM`: `ST_OFF` to `ST_REC` on a software write of 1 to the enable, provided no debug exception arrives in the same cycle.
- `T_DISARM`: `ST_REC` to `ST_OFF` on a software write of 0.
- `T_DBG_HALT`: `ST_REC` to `ST_OFF` on a debug exception. This transition wins over any software write in the same cycle.

Top module: `xfer_trace_stack`

## Requirements
- R1: After reset, the control register reads 0, the index reads 0 and all sixteen entry words read 0.
- R2: A write to address 0 sets the enable from bit 0 of the write data. A read of address 0 returns the enable in bit 0 and 0 in every other bit.
- R3: Each event is presented in one clock cycle with `evt_valid` high. While the enable is set, an event of kind 0 (taken branch), 1 (interrupt) or 2 (exception) stores its from/to pair. The index at address 1 advances by one, modulo 8. The new pair reads back from the cycle after the event.
- R4: While the enable is clear, events of any kind store nothing and leave the index unchanged.
- R5: An event of kind 3 (debug exception) is never stored. If the enable is set, kind 3 clears it, and the control register reads 0 from the next cycle.
- R6: If a debug exception and a software write of 1 to the enable arrive in the same cycle, the enable ends up clear.
- R7: Clearing the enable, whether by software or by a debug exception, leaves every stored pair and the index unchanged.
- R8: Address 16+k returns the from address and address 24+k returns the to address of the pair k steps older than the newest (k = 0..7). Once more than eight pairs have been stored, the oldest is overwritten. A slot that has never been written reads 0.
- R9: Writes to the index address and to the entry addresses have no effect on anything that can be read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_valid | input | 1 | A control transfer is reported this cycle |
| evt_kind | input | 2 | 0 branch, 1 interrupt, 2 exception, 3 debug exception |
| evt_from | input | PC_W | Address the transfer left from |
| evt_to | input | PC_W | Address the transfer went to |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address (read and write) |
| reg_wdata | input | PC_W | Register write data |
| reg_rdata | output | PC_W | Read data for `reg_addr`, combinational |

## Verification
The first pattern is a run of branches, interrupts and exceptions that is long enough to wrap the ring. After every event all sixteen entry words and the index are compared with a history computed in the bench. This separates errors in the direction of the lookback, errors in the index arithmetic and failures to overwrite the oldest pair. The second pattern sends events while the enable is clear and sends debug exceptions in both machine states. This shows whether the gating and the kind-3 exclusion are honoured, and whether history survives a stop. The third pattern collides a debug exception with a software arm, and writes junk to the read-only addresses. These two cases expose a wrong priority and stray write decoding.

// File: rtl/xts_pkg.sv
package xts_pkg;

    typedef enum logic [1:0] {
        XK_BRANCH = 2'd0,
        XK_IRQ    = 2'd1,
        XK_EXC    = 2'd2,
        XK_DBG    = 2'd3
    } xfer_kind_e;

    typedef enum logic {
        ST_OFF = 1'b0,
        ST_REC = 1'b1
    } rec_state_e;

    // upper two address bits select the entry windows
    localparam logic [1:0] WIN_FROM = 2'b10;
    localparam logic [1:0] WIN_TO   = 2'b11;

endpackage

// File: rtl/xts_ctrl.sv
module xts_ctrl
    import xts_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sw_ctrl_wr,
    input  logic sw_ctrl_en,
    input  logic dbg_hit,
    output logic rec_en
);

    rec_state_e state_q;
    rec_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                // T_ARM, suppressed by a concurrent debug exception
                if (sw_ctrl_wr && sw_ctrl_en && !dbg_hit) begin
                    state_d = ST_REC;
                end
            end
            ST_REC: begin
                if (dbg_hit) begin
                    state_d = ST_OFF;              // T_DBG_HALT
                end else if (sw_ctrl_wr && !sw_ctrl_en) begin
                    state_d = ST_OFF;              // T_DISARM
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_comb begin
        rec_en = (state_q == ST_REC);
    end

endmodule

// File: rtl/xts_ring.sv
module xts_ring #(
    parameter int DEPTH = 8,
    parameter int PC_W  = 32,
    parameter int PW    = $clog2(DEPTH)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [PC_W-1:0] push_from,
    input  logic [PC_W-1:0] push_to,
    input  logic [PW-1:0]   rd_back,
    output logic [PW-1:0]   tos,
    output logic [PC_W-1:0] rd_from,
    output logic [PC_W-1:0] rd_to
);

    logic [PW-1:0]   tos_q;
    logic [PW-1:0]   tos_nxt;
    logic [PW-1:0]   rd_slot;
    logic [PC_W-1:0] from_mem [DEPTH];
    logic [PC_W-1:0] to_mem   [DEPTH];

    assign tos_nxt = tos_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tos_q <= '0;
            for (int s = 0; s < DEPTH; s++) begin
                from_mem[s] <= '0;
                to_mem[s]   <= '0;
            end
        end else if (push) begin
            tos_q <= tos_nxt;
            for (int s = 0; s < DEPTH; s++) begin
                if (tos_nxt == PW'(s)) begin
                    from_mem[s] <= push_from;
                    to_mem[s]   <= push_to;
                end
            end
        end
    end

    // lookback: ring size is a power of two, so the subtraction wraps
    assign rd_slot = tos_q - rd_back;
    assign rd_from = from_mem[rd_slot];
    assign rd_to   = to_mem[rd_slot];
    assign tos     = tos_q;

endmodule

// File: rtl/xts_regif.sv
module xts_regif
    import xts_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int PC_W   = 32,
    parameter int PW     = $clog2(DEPTH),
    parameter int ADDR_W = PW + 2
) (
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [PC_W-1:0]   reg_wdata,
    input  logic              rec_en,
    input  logic [PW-1:0]     tos,
    input  logic [PC_W-1:0]   rd_from,
    input  logic [PC_W-1:0]   rd_to,
    output logic              sw_ctrl_wr,
    output logic              sw_ctrl_en,
    output logic [PW-1:0]     rd_back,
    output logic [PC_W-1:0]   reg_rdata
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_TOS  = ADDR_W'(1);

    logic [1:0] win;

    assign win        = reg_addr[ADDR_W-1 -: 2];
    assign rd_back    = reg_addr[PW-1:0];
    assign sw_ctrl_wr = reg_wr && (reg_addr == A_CTRL);
    assign sw_ctrl_en = reg_wdata[0];

    always_comb begin
        reg_rdata = '0;
        if (win == WIN_FROM) begin
            reg_rdata = rd_from;
        end else if (win == WIN_TO) begin
            reg_rdata = rd_to;
        end else if (reg_addr == A_CTRL) begin
            reg_rdata[0] = rec_en;
        end else if (reg_addr == A_TOS) begin
            reg_rdata[PW-1:0] = tos;
        end
    end

endmodule

// File: rtl/xfer_trace_stack.sv
module xfer_trace_stack
    import xts_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int PC_W   = 32,
    parameter int ADDR_W = $clog2(DEPTH) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_valid,
    input  logic [1:0]        evt_kind,
    input  logic [PC_W-1:0]   evt_from,
    input  logic [PC_W-1:0]   evt_to,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [PC_W-1:0]   reg_wdata,
    output logic [PC_W-1:0]   reg_rdata
);

    localparam int PW = $clog2(DEPTH);

    xfer_kind_e      kind;
    logic            dbg_hit;
    logic            push;
    logic            rec_en;
    logic            sw_ctrl_wr;
    logic            sw_ctrl_en;
    logic [PW-1:0]   rd_back;
    logic [PW-1:0]   tos_q;
    logic [PC_W-1:0] rd_from;
    logic [PC_W-1:0] rd_to;

    assign kind    = xfer_kind_e'(evt_kind);
    assign dbg_hit = evt_valid && (kind == XK_DBG);
    assign push    = evt_valid && rec_en && (kind != XK_DBG);

    xts_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .sw_ctrl_wr (sw_ctrl_wr),
        .sw_ctrl_en (sw_ctrl_en),
        .dbg_hit    (dbg_hit),
        .rec_en     (rec_en)
    );

    xts_ring #(.DEPTH(DEPTH), .PC_W(PC_W), .PW(PW)) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_from (evt_from),
        .push_to   (evt_to),
        .rd_back   (rd_back),
        .tos       (tos_q),
        .rd_from   (rd_from),
        .rd_to     (rd_to)
    );

    xts_regif #(.DEPTH(DEPTH), .PC_W(PC_W), .PW(PW), .ADDR_W(ADDR_W)) u_regif (
        .reg_addr   (reg_addr),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .rec_en     (rec_en),
        .tos        (tos_q),
        .rd_from    (rd_from),
        .rd_to      (rd_to),
        .sw_ctrl_wr (sw_ctrl_wr),
        .sw_ctrl_en (sw_ctrl_en),
        .rd_back    (rd_back),
        .reg_rdata  (reg_rdata)
    );

endmodule

// File: rtl/xfer_trace_stack_chk.sv
module xfer_trace_stack_chk #(
    parameter int PW     = 3,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              evt_valid,
    input logic [1:0]        evt_kind,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              wbit0,
    input logic              rec_en,
    input logic [PW-1:0]     tos
);

    logic dbg_in;
    logic arm_wr;
    assign dbg_in = evt_valid && (evt_kind == 2'd3);
    assign arm_wr = reg_wr && (reg_addr == '0) && wbit0;

    a_r1_reset_state: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rec_en && tos == '0));

    a_r2_arm_write: assert property (@(posedge clk) disable iff (!rst_n)
        (arm_wr && !dbg_in) |=> rec_en);

    a_r3_push_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (rec_en && evt_valid && !dbg_in) |=> (tos == PW'($past(tos) + 1'b1)));

    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rec_en |=> $stable(tos));

    a_r5_dbg_clears: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_in |=> !rec_en);

    a_r5_dbg_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_in |=> $stable(tos));

    a_r6_dbg_beats_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_in && arm_wr) |=> !rec_en);

endmodule

bind xfer_trace_stack xfer_trace_stack_chk #(.PW(PW), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_valid (evt_valid),
    .evt_kind  (evt_kind),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .wbit0     (reg_wdata[0]),
    .rec_en    (rec_en),
    .tos       (tos_q)
);

// File: tb/xfer_trace_stack_tb.sv
module xfer_trace_stack_tb;

    localparam int DEPTH = 8;
    localparam int PC_W  = 32;
    localparam int AW    = 5;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            evt_valid;
    logic [1:0]      evt_kind;
    logic [PC_W-1:0] evt_from;
    logic [PC_W-1:0] evt_to;
    logic            reg_wr;
    logic [AW-1:0]   reg_addr;
    logic [PC_W-1:0] reg_wdata;
    logic [PC_W-1:0] reg_rdata;

    always #5 clk = ~clk;

    xfer_trace_stack #(.DEPTH(DEPTH), .PC_W(PC_W), .ADDR_W(AW)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_valid (evt_valid),
        .evt_kind  (evt_kind),
        .evt_from  (evt_from),
        .evt_to    (evt_to),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata)
    );

    int checks = 0;
    int fails  = 0;
    int n      = 0;
    bit m_en   = 1'b0;
    logic [PC_W-1:0] hf [0:63];
    logic [PC_W-1:0] ht [0:63];

    task automatic chk(input string req, input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [PC_W-1:0] d);
        reg_addr = AW'(a);
        #1;
        d = reg_rdata;
    endtask

    task automatic check_all(input string req);
        logic [PC_W-1:0] d;
        rd(0, d);
        chk({req, " ctrl"}, d, {31'd0, m_en});
        rd(1, d);
        chk({req, " tos"}, d, PC_W'(n % DEPTH));
        for (int k = 0; k < DEPTH; k++) begin
            rd(16 + k, d);
            chk({req, " from"}, d, (k < n) ? hf[n-1-k] : '0);
            rd(24 + k, d);
            chk({req, " to"}, d, (k < n) ? ht[n-1-k] : '0);
        end
    endtask

    task automatic model_evt(input int kind, input logic [PC_W-1:0] f, input logic [PC_W-1:0] t);
        if (kind != 3 && m_en) begin
            hf[n] = f;
            ht[n] = t;
            n++;
        end
        if (kind == 3) m_en = 1'b0;
    endtask

    task automatic evt(input int kind, input logic [PC_W-1:0] f, input logic [PC_W-1:0] t);
        @(negedge clk);
        evt_valid = 1'b1;
        evt_kind  = 2'(kind);
        evt_from  = f;
        evt_to    = t;
        @(negedge clk);
        evt_valid = 1'b0;
        model_evt(kind, f, t);
    endtask

    task automatic wr(input int a, input logic [PC_W-1:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = AW'(a);
        reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a == 0) m_en = d[0];
    endtask

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [PC_W-1:0] d;
        logic [PC_W-1:0] f;
        rst_n = 1'b0;
        evt_valid = 1'b0;
        evt_kind = '0;
        evt_from = '0;
        evt_to = '0;
        reg_wr = 1'b0;
        reg_addr = '0;
        reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R2: enable bit only from bit 0, other bits read 0
        wr(0, 32'h0000_0001);
        rd(0, d); chk("R2 set", d, 32'h1);
        wr(0, 32'hFFFF_FFFE);
        rd(0, d); chk("R2 clear", d, 32'h0);
        wr(0, 32'h8000_0001);
        rd(0, d); chk("R2 set high bits", d, 32'h1);

        // R3/R8: recording with wrap, all kinds 0..2
        for (int i = 0; i < 11; i++) begin
            f = 32'h1000_0000 + i * 32'h111;
            evt(i % 3, f, f ^ 32'h00FF_0000);
            check_all("R3/R8");
        end

        // R9: writes to read-only addresses
        wr(1, 32'h5);
        wr(16, 32'hDEAD_BEEF);
        wr(29, 32'h1234_5678);
        wr(7, 32'hFFFF_FFFF);
        check_all("R9");

        // R5 and R7: debug exception stops recording, keeps history
        evt(3, 32'hAAAA_0000, 32'hBBBB_0000);
        check_all("R5/R7");

        // R4: disabled events ignored
        evt(0, 32'h2222_0000, 32'h3333_0000);
        evt(2, 32'h4444_0000, 32'h5555_0000);
        check_all("R4");

        // R5: debug exception while off
        evt(3, 32'h6666_0000, 32'h7777_0000);
        check_all("R5 off");

        // R7: software clear keeps history
        wr(0, 32'h1);
        evt(1, 32'h0BAD_0001, 32'h0BAD_0002);
        wr(0, 32'h0);
        check_all("R7");

        // R6: debug exception collides with software arm
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = '0; reg_wdata = 32'h1;
        evt_valid = 1'b1; evt_kind = 2'd3;
        evt_from = 32'hCCCC_0000; evt_to = 32'hDDDD_0000;
        @(negedge clk);
        reg_wr = 1'b0; evt_valid = 1'b0;
        m_en = 1'b0;
        check_all("R6");

        // R6 while recording, then R8 further wrap
        wr(0, 32'h1);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = '0; reg_wdata = 32'h1;
        evt_valid = 1'b1; evt_kind = 2'd3;
        @(negedge clk);
        reg_wr = 1'b0; evt_valid = 1'b0;
        m_en = 1'b0;
        check_all("R6 rec");

        wr(0, 32'h1);
        for (int i = 0; i < 12; i++) begin
            f = 32'h8000_0000 + i * 32'h0104_0021;
            evt((i * 2) % 3, f, ~f);
            check_all("R8");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule